// File: doc/BRIEF.md
# GPIO Interrupt Router

This block takes a wide vector of GPIO pad inputs and routes a chosen pad onto each of eight interrupt lines. Every line has its own trigger condition: high level, low level, rising edge, falling edge or both edges. The block conditions the chosen signal so that the downstream interrupt controller only ever sees an active-high level or a one-cycle high pulse. Low levels and falling edges are handled by inverting the synchronised pad signal ahead of a common level/edge stage. A both-edges setting takes priority over the single-edge and polarity settings of a line.

Software programs the router through a 32-bit word-addressed register port. There are four words: a trigger control word, two words of pad-select bytes and one word of per-line debounce lengths. Each selected pad passes through a two-flop synchroniser and then an optional debounce. The debounce accepts a new value only after it has held for a programmed number of consecutive clocks. A global enable bit forces all lines low while it is clear.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset all four register words read 0, the global enable is off, and every line is in active-high level mode selecting pad 0 with no debounce. The `irq_out` vector is 0.
- R2: Word 0 (trigger control) reads back bits 23:0 and bit 31 as last written, and reads bits 30:24 as zero. Words 1, 2 and 3 read back all 32 bits as last written.
- R3: Line n takes the pad whose number is the byte at bits (n mod 4)*8 upward. For lines 0–3 that byte is in word 1; for lines 4–7 it is in word 2.
- R4: In high-level mode (bits n, 8+n and 16+n of word 0 all clear), with the debounce field at 0 and bit 31 set, `irq_out[n]` equals the selected pad delayed by three clocks.
- R5: Setting bit 16+n (low polarity) with bits n and 8+n clear makes `irq_out[n]` high while the selected pad is low, with the same three-clock latency.
- R6: Setting bit n (edge mode) with bit 16+n clear gives a single one-cycle high pulse on `irq_out[n]` three clocks after the pad rises, and no pulse when it falls.
- R7: Setting bits n and 16+n gives the one-cycle pulse on a falling pad edge and none on a rising edge.
- R8: Setting bit 8+n gives a one-cycle pulse on every pad transition, in both directions. This applies whatever bits n and 16+n hold, and the line stays low while the pad holds a steady level.
- R9: While bit 31 of word 0 is clear, every bit of `irq_out` is low in the same cycle. Setting it exposes the conditioned lines from the next cycle on.
- R10: Word 3 holds a 4-bit debounce length F for line n at bits 4n upward. With F nonzero, a synchronised pad level is accepted only after F+1 equal consecutive samples, so a pulse shorter than that is dropped. A held level reaches the output F+1 clocks later than it does with F at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_waddr | input | 2 | Word index (byte offset divided by four) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at `reg_waddr`, combinational |
| pad_in | input | 256 | Asynchronous GPIO pad levels |
| irq_out | output | 8 | Conditioned active-high interrupt lines |

## Verification
The select test raises single pads such as 37, 200, 255 and 1, each picked by a different line. Each must light exactly its own line, which shows up any swapped byte lane or word. The level tests hold pads high and low across several cycles to separate level behaviour from pulses, and they sample one cycle early to pin down the three-clock latency. The edge tests toggle a pad under rising, falling and both-edge settings. A pulse on the wrong transition, or one that lasts more than a cycle, tells the modes apart and shows that the both-edge bit wins over the others. The debounce test sends a two-clock glitch, which must vanish, and then a held level, which must appear at exactly the extended latency.

// File: rtl/gir_pkg.sv
// Package: register layout constants shared by the GPIO interrupt router.
// Assumes a 32-bit register word and at most eight interrupt lines.
package gir_pkg;
    localparam int REG_W        = 32;
    localparam int EDGE_LSB     = 0;   // single-edge enable, one bit per line
    localparam int BOTH_LSB     = 8;   // both-edge enable, one bit per line
    localparam int POL_LSB      = 16;  // low/falling polarity, one bit per line
    localparam int EN_BIT       = 31;  // global line enable
    localparam int SEL_STRIDE   = 8;   // bit pitch of a select byte
    localparam int SEL_PER_WORD = 4;   // select bytes packed per word
    localparam int FLT_STRIDE   = 4;   // bit pitch of a debounce field

    typedef enum logic [1:0] {
        W_CTRL   = 2'd0,
        W_SEL_LO = 2'd1,
        W_SEL_HI = 2'd2,
        W_FILT   = 2'd3
    } reg_word_e;
endpackage

// File: rtl/gir_regs.sv
// Module: register file of the router. It holds four words, masks off
// unimplemented bits on write and decodes per-line fields. Read data is
// combinational from the stored words.
// Assumes NUM_CH <= 8, SEL_W <= 8 and FLT_W <= 4 so the fixed layout fits.
module gir_regs
    import gir_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 8,
    parameter int FLT_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [1:0]                       waddr,
    input  logic [REG_W-1:0]                 wdata,
    output logic [REG_W-1:0]                 rdata,
    output logic                             glb_en,
    output logic [NUM_CH-1:0]                edge_bits,
    output logic [NUM_CH-1:0]                both_bits,
    output logic [NUM_CH-1:0]                pol_bits,
    output logic [NUM_CH-1:0][SEL_W-1:0]     ch_sel,
    output logic [NUM_CH-1:0][FLT_W-1:0]     ch_flt
);
    localparam int NUM_WORDS = 4;

    logic [REG_W-1:0] word_q [NUM_WORDS];

    // Writable-bit mask of each word.
    function automatic logic [REG_W-1:0] word_mask(input logic [1:0] w);
        logic [REG_W-1:0] m;
        m = '0;
        case (reg_word_e'(w))
            W_CTRL: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    m[EDGE_LSB + i] = 1'b1;
                    m[BOTH_LSB + i] = 1'b1;
                    m[POL_LSB + i]  = 1'b1;
                end
                m[EN_BIT] = 1'b1;
            end
            W_SEL_LO, W_SEL_HI: begin
                for (int i = 0; i < SEL_PER_WORD; i++) begin
                    if ((int'(w) - 1) * SEL_PER_WORD + i < NUM_CH)
                        m[i*SEL_STRIDE +: SEL_W] = '1;
                end
            end
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    m[i*FLT_STRIDE +: FLT_W] = '1;
            end
        endcase
        return m;
    endfunction

    // Purpose: store masked write data, clear every word on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
        end else if (wr_en) begin
            word_q[waddr] <= wdata & word_mask(waddr);
        end
    end

    // Purpose: return the addressed word.
    always_comb rdata = word_q[waddr];

    assign glb_en    = word_q[W_CTRL][EN_BIT];
    assign edge_bits = word_q[W_CTRL][EDGE_LSB +: NUM_CH];
    assign both_bits = word_q[W_CTRL][BOTH_LSB +: NUM_CH];
    assign pol_bits  = word_q[W_CTRL][POL_LSB +: NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_field
        assign ch_sel[c] = word_q[int'(W_SEL_LO) + c / SEL_PER_WORD][(c % SEL_PER_WORD)*SEL_STRIDE +: SEL_W];
        assign ch_flt[c] = word_q[W_FILT][c*FLT_STRIDE +: FLT_W];
    end

    // R1: the cycle reset is released, every control field is cleared.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!glb_en && edge_bits == '0 && both_bits == '0 && pol_bits == '0));

    // R2: a control write reads back its implemented bits, reserved bits zero.
    assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == 2'(W_CTRL)) |=>
            (waddr != 2'(W_CTRL)) ||
            (rdata[30:24] == 7'd0 &&
             rdata[EN_BIT] == $past(wdata[EN_BIT]) &&
             rdata[POL_LSB +: NUM_CH] == $past(wdata[POL_LSB +: NUM_CH]) &&
             rdata[EDGE_LSB +: NUM_CH] == $past(wdata[EDGE_LSB +: NUM_CH])));
endmodule

// File: rtl/gir_debounce.sv
// Module: sample-count debounce for one synchronised line. With a zero
// length the input passes straight through. Otherwise a new value is taken
// only after length+1 equal consecutive samples.
// Assumes din is already synchronous to clk.
module gir_debounce #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [FLT_W-1:0] flt_len,
    output logic             dout
);
    logic             cand_q;
    logic             acc_q;
    logic [FLT_W-1:0] cnt_q;
    logic             bypass;

    assign bypass = (flt_len == '0);

    // Purpose: track the candidate level and count how long it has held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= 1'b0;
            acc_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (bypass) begin
            cand_q <= din;
            acc_q  <= din;
            cnt_q  <= '0;
        end else if (din != cand_q) begin
            cand_q <= din;
            cnt_q  <= '0;
        end else if (cnt_q >= flt_len - FLT_W'(1)) begin
            acc_q  <= cand_q;
        end else begin
            cnt_q  <= cnt_q + FLT_W'(1);
        end
    end

    assign dout = bypass ? din : acc_q;

    // R10: an accepted value always matches the sample seen at that edge.
    assert_accept_matches_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> ($past(din) == acc_q));
endmodule

// File: rtl/gir_channel.sv
// Module: one interrupt line. It picks a pad, synchronises it, debounces it,
// applies the polarity and then a level, single-edge or both-edge stage.
// The result is registered, so latency is three clocks without debounce.
// Assumes pad inputs are asynchronous and that the select is static while in use.
module gir_channel #(
    parameter int NUM_PADS = 256,
    parameter int SEL_W    = 8,
    parameter int FLT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads,
    input  logic [SEL_W-1:0]    sel,
    input  logic [FLT_W-1:0]    flt_len,
    input  logic                edge_en,
    input  logic                both_en,
    input  logic                pol_low,
    output logic                irq_raw
);
    logic pad_pick;
    logic sync1_q, sync2_q;
    logic filt, filt_d_q;
    logic cond_now, cond_prev;
    logic single_hit;
    logic hit;
    logic irq_q;

    // Purpose: pad multiplexer, out-of-range selects read as low.
    always_comb pad_pick = (int'(sel) < NUM_PADS) ? pads[sel] : 1'b0;

    // Purpose: two-flop synchroniser for the chosen pad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pad_pick;
            sync2_q <= sync1_q;
        end
    end

    gir_debounce #(.FLT_W(FLT_W)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (sync2_q),
        .flt_len (flt_len),
        .dout    (filt)
    );

    // Purpose: previous filtered sample for the edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_d_q <= 1'b0;
        else        filt_d_q <= filt;
    end

    // Polarity applies to both samples, so rewriting it makes no false edge.
    assign cond_now   = filt ^ pol_low;
    assign cond_prev  = filt_d_q ^ pol_low;
    assign single_hit = cond_now & ~cond_prev;

    // Purpose: pick the trigger stage; the both-edge setting wins.
    always_comb begin
        if (both_en)      hit = filt ^ filt_d_q;
        else if (edge_en) hit = single_hit;
        else              hit = cond_now;
    end

    // Purpose: register the conditioned line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= hit;
    end

    assign irq_raw = irq_q;

    // R6: with polarity unchanged, a single-edge event never lasts two cycles.
    assert_single_edge_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        single_hit |=> !(single_hit && $stable(pol_low)));
endmodule

// File: rtl/gpio_irq_router.sv
// Module: top of the GPIO interrupt router. It joins the register file to
// one conditioning channel per interrupt line and gates every line with the
// global enable.
// Assumes NUM_PADS <= 256 and NUM_CH <= 8, as the register layout requires.
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_PADS = 256,
    parameter int NUM_CH   = 8,
    parameter int FLT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_waddr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_CH-1:0]   irq_out
);
    localparam int SEL_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

    logic                         glb_en;
    logic [NUM_CH-1:0]            edge_bits, both_bits, pol_bits;
    logic [NUM_CH-1:0][SEL_W-1:0] ch_sel;
    logic [NUM_CH-1:0][FLT_W-1:0] ch_flt;
    logic [NUM_CH-1:0]            irq_raw;

    gir_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .FLT_W(FLT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .glb_en    (glb_en),
        .edge_bits (edge_bits),
        .both_bits (both_bits),
        .pol_bits  (pol_bits),
        .ch_sel    (ch_sel),
        .ch_flt    (ch_flt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gir_channel #(.NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .FLT_W(FLT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pads    (pad_in),
            .sel     (ch_sel[c]),
            .flt_len (ch_flt[c]),
            .edge_en (edge_bits[c]),
            .both_en (both_bits[c]),
            .pol_low (pol_bits[c]),
            .irq_raw (irq_raw[c])
        );
    end

    // Purpose: global enable gates every line in the same cycle.
    always_comb irq_out = glb_en ? irq_raw : '0;
endmodule

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_waddr = 2'd0;
    logic [31:0]  reg_wdata = 32'd0;
    logic [31:0]  reg_rdata;
    logic [255:0] pad_in = '0;
    logic [7:0]   irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_irq_router dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_waddr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic set_pad(input int idx, input logic v);
        @(negedge clk);
        pad_in[idx] = v;
    endtask

    // OR of irq_out over n cycles, to prove no pulse appears.
    task automatic quiet_for(input int n, input string tag);
        logic [7:0] seen;
        seen = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen |= irq_out;
        end
        check(tag, {24'd0, seen}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 irq_out after reset", {24'd0, irq_out}, 32'd0);
        for (int w = 0; w < 4; w++) reg_chk(2'(w), 32'd0, "R1 word after reset");
    endtask

    task automatic t_readback;
        reg_wr(2'd0, 32'hFFFF_FFFF);
        reg_chk(2'd0, 32'h80FF_FFFF, "R2 control reserved bits");
        reg_wr(2'd1, 32'hA5C3_1E07);
        reg_chk(2'd1, 32'hA5C3_1E07, "R2 select low word");
        reg_wr(2'd2, 32'h5A3C_E170);
        reg_chk(2'd2, 32'h5A3C_E170, "R2 select high word");
        reg_wr(2'd3, 32'h1234_5678);
        reg_chk(2'd3, 32'h1234_5678, "R2 debounce word");
        for (int w = 0; w < 4; w++) reg_wr(2'(w), 32'd0);
        reg_chk(2'd0, 32'd0, "R2 control cleared");
        waitn(6);
    endtask

    task automatic t_enable;
        set_pad(0, 1'b1);
        waitn(6);
        check("R9 outputs low while disabled", {24'd0, irq_out}, 32'd0);
        reg_wr(2'd0, 32'h8000_0000);
        check("R9 enable exposes lines", {24'd0, irq_out}, 32'h0000_00FF);
        reg_wr(2'd0, 32'h0000_0000);
        check("R9 disable forces low", {24'd0, irq_out}, 32'd0);
        set_pad(0, 1'b0);
        waitn(6);
    endtask

    task automatic t_select;
        reg_wr(2'd1, 32'h0A14_1EC8);  // ch0=200 ch1=30 ch2=20 ch3=10
        reg_wr(2'd2, 32'hFF01_2563);  // ch4=99 ch5=37 ch6=1 ch7=255
        reg_wr(2'd0, 32'h8000_0000);
        waitn(6);
        check("R4 idle level", {24'd0, irq_out}, 32'd0);
        set_pad(37, 1'b1);
        waitn(2);
        check("R4 not yet after two clocks", {24'd0, irq_out}, 32'd0);
        waitn(1);
        check("R3 pad 37 reaches line 5", {24'd0, irq_out}, 32'h20);
        waitn(3);
        check("R4 level held", {24'd0, irq_out}, 32'h20);
        set_pad(37, 1'b0);
        waitn(3);
        check("R4 level released", {24'd0, irq_out}, 32'd0);
        set_pad(200, 1'b1);
        waitn(3);
        check("R3 pad 200 reaches line 0", {24'd0, irq_out}, 32'h01);
        set_pad(200, 1'b0);
        set_pad(255, 1'b1);
        waitn(3);
        check("R3 pad 255 reaches line 7", {24'd0, irq_out}, 32'h80);
        set_pad(255, 1'b0);
        set_pad(1, 1'b1);
        waitn(3);
        check("R3 pad 1 reaches line 6", {24'd0, irq_out}, 32'h40);
        set_pad(1, 1'b0);
        waitn(4);
    endtask

    task automatic t_level_low;
        reg_wr(2'd0, 32'h8004_0000);  // line 2 low polarity, pad 20
        waitn(6);
        check("R5 low level active with pad low", {24'd0, irq_out}, 32'h04);
        set_pad(20, 1'b1);
        waitn(2);
        check("R5 still active two clocks on", {24'd0, irq_out}, 32'h04);
        waitn(1);
        check("R5 inactive with pad high", {24'd0, irq_out}, 32'd0);
        set_pad(20, 1'b0);
        waitn(3);
        check("R5 active again", {24'd0, irq_out}, 32'h04);
    endtask

    task automatic t_rise;
        reg_wr(2'd0, 32'h8000_0002);  // line 1 rising edge, pad 30
        waitn(6);
        check("R6 idle", {24'd0, irq_out}, 32'd0);
        set_pad(30, 1'b1);
        waitn(2);
        check("R6 no pulse yet", {24'd0, irq_out}, 32'd0);
        waitn(1);
        check("R6 pulse on rise", {24'd0, irq_out}, 32'h02);
        waitn(1);
        check("R6 pulse is one cycle", {24'd0, irq_out}, 32'd0);
        quiet_for(4, "R6 quiet while held");
        set_pad(30, 1'b0);
        quiet_for(6, "R6 no pulse on fall");
    endtask

    task automatic t_fall;
        reg_wr(2'd0, 32'h8002_0002);  // line 1 falling edge
        waitn(6);
        check("R7 idle", {24'd0, irq_out}, 32'd0);
        set_pad(30, 1'b1);
        quiet_for(6, "R7 no pulse on rise");
        set_pad(30, 1'b0);
        waitn(2);
        check("R7 no pulse yet", {24'd0, irq_out}, 32'd0);
        waitn(1);
        check("R7 pulse on fall", {24'd0, irq_out}, 32'h02);
        waitn(1);
        check("R7 pulse is one cycle", {24'd0, irq_out}, 32'd0);
    endtask

    task automatic t_both;
        reg_wr(2'd0, 32'h8002_0202);  // line 1 both edges, overriding edge+polarity
        waitn(6);
        check("R8 idle", {24'd0, irq_out}, 32'd0);
        set_pad(30, 1'b1);
        waitn(3);
        check("R8 pulse on rise", {24'd0, irq_out}, 32'h02);
        waitn(1);
        check("R8 rise pulse one cycle", {24'd0, irq_out}, 32'd0);
        quiet_for(4, "R8 quiet while held high");
        set_pad(30, 1'b0);
        waitn(3);
        check("R8 pulse on fall", {24'd0, irq_out}, 32'h02);
        waitn(1);
        check("R8 fall pulse one cycle", {24'd0, irq_out}, 32'd0);
    endtask

    task automatic t_filter;
        reg_wr(2'd0, 32'h8000_0000);
        reg_wr(2'd3, 32'h0000_0003);  // line 0 debounce length 3
        waitn(6);
        @(negedge clk); pad_in[200] = 1'b1;
        @(negedge clk);
        @(negedge clk); pad_in[200] = 1'b0;
        quiet_for(14, "R10 short glitch dropped");
        set_pad(200, 1'b1);
        waitn(6);
        check("R10 held level not yet accepted", {24'd0, irq_out}, 32'd0);
        waitn(1);
        check("R10 held level accepted", {24'd0, irq_out}, 32'h01);
        set_pad(200, 1'b0);
        waitn(10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_enable();
        t_select();
        t_level_low();
        t_rise();
        t_fall();
        t_both();
        t_filter();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule